// File: doc/BRIEF.md
# Single-Wire EEPROM Bus Master Sequencer

This block runs whole transactions on a single-wire serial EEPROM bus. It works one level above a bit transceiver, which turns single bit requests into self-clocked line activity. The sequencer decides which bits go out and which come back. It checks the acknowledge slots, and it hands received bytes to the user.

A user command is an opcode byte, an optional 16-bit word address, a data byte count and a direction. The sequencer can insert a long standby pulse, and it then always sends a start header, the device address, the opcode, the address bytes (if any) and the data. Bytes go out most significant bit first.

Every byte is followed by a two-bit acknowledge slot. The master bit says whether the transfer goes on. The slave bit is then sampled to confirm that the slave is still in step. When the slave does not acknowledge, the command ends with an error, and the next command opens with a standby pulse.

Top module: `useq_master`

## Requirements
- R1: After reset, the first accepted command begins with `line_stby` high for exactly STBY_CYC consecutive cycles. No `bit_go` is issued while it is high.
- R2: Every command starts with the byte 0x55 sent MSB first, a master bit of 1, and one receive slot. That slot's result is ignored: both an acknowledge and a missing transition let the command continue.
- R3: After the header, the device byte 0xA0 is sent, followed by the opcode byte `cmd_op`.
- R4: When `cmd_addr_en` is 1, the address high byte `cmd_addr[15:8]` is sent after the opcode, followed by the low byte `cmd_addr[7:0]`.
- R5: The master bit after a byte is 1 when more bytes follow in the command and 0 after the final byte. This holds for sent and received bytes alike.
- R6: After every byte except the header, a receive slot returning `bit_rx`=1 with `bit_miss`=0 counts as an acknowledge. Any other result raises `error` for one cycle and ends the command with no further `bit_go`. No `done` is raised in that case.
- R7: After an error, the next command begins with a standby pulse. After a command that ended with `done`, the next command skips it.
- R8: In a write (`cmd_read`=0), the data bytes are taken from `wr_data` one per `wr_ready` pulse and sent in the order taken. The count of data bytes is `cmd_len`.
- R9: In a read (`cmd_read`=1), `cmd_len` bytes are received MSB first. Each byte appears on `rd_data` with a one-cycle `rd_valid` only after its slave acknowledge. The last byte is followed by a master bit of 0 and a slave acknowledge before `done`.
- R10: A command with `cmd_addr_en`=0 and `cmd_len`=0 ends after the opcode byte, with a master bit of 0.
- R11: `cmd_ready` is 1 only while idle. Command inputs presented while a command is running are ignored.
- R12: `done` and `error` are single-cycle pulses, never high together, and the block is idle (`cmd_ready`=1) in the cycle they appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Idle and able to take a command |
| cmd_op | input | 8 | Opcode byte |
| cmd_addr | input | 16 | Word address |
| cmd_addr_en | input | 1 | Send the two address bytes |
| cmd_read | input | 1 | 1: data bytes are received, 0: sent |
| cmd_len | input | LEN_W | Number of data bytes |
| wr_valid | input | 1 | Write byte available |
| wr_data | input | 8 | Write byte |
| wr_ready | output | 1 | Pulse: write byte taken |
| rd_valid | output | 1 | Pulse: received byte valid |
| rd_data | output | 8 | Received byte |
| done | output | 1 | Pulse: command finished |
| error | output | 1 | Pulse: missing slave acknowledge |
| line_stby | output | 1 | Hold line idle-high (standby pulse) |
| bit_go | output | 1 | Pulse: start one bit slot |
| bit_op | output | 1 | 0: send `bit_tx`, 1: receive |
| bit_tx | output | 1 | Bit value to send |
| bit_done | input | 1 | Bit slot finished |
| bit_rx | input | 1 | Received bit value (1 = rising mid-bit edge) |
| bit_miss | input | 1 | No mid-bit transition seen |

## Verification
The hardest case to reach is a missing acknowledge on the very last slot of a read. That slot comes after the master has already sent its closing 0, so the block must report an error and must not report done. The bench model of the transceiver holds a per-command script of responses for the receive slots, and it can place a no-acknowledge on any numbered slot. One vector puts it on the final read slot, another on an address byte. A third gives the header slot a real acknowledge to show that slot is ignored. The standby pulse after the error is then checked on the following command.

// File: rtl/useq_pkg.sv
package useq_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_STBY, S_LOAD, S_BITS, S_MAK, S_SAK
  } st_e;

  typedef enum logic [2:0] {
    PH_HDR, PH_DEV, PH_OP, PH_AH, PH_AL, PH_DAT
  } ph_e;

  localparam logic BOP_SEND = 1'b0;
  localparam logic BOP_RECV = 1'b1;
endpackage

// File: rtl/useq_stby_timer.sv
module useq_stby_timer #(
  parameter int CYC = 60000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic active,
  output logic fin
);
  localparam int CW = $clog2(CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
      fin    <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (start && !active) begin
        active <= 1'b1;
        cnt    <= '0;
      end else if (active) begin
        if (cnt == CW'(CYC - 1)) begin
          active <= 1'b0;
          fin    <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/useq_byte_shifter.sv
module useq_byte_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         din,
  output logic         msb,
  output logic [W-1:0] q
);
  logic [W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst)        sr <= '0;
    else if (load)  sr <= load_val;
    else if (shift) sr <= {sr[W-2:0], din};
  end

  assign msb = sr[W-1];
  assign q   = sr;
endmodule

// File: rtl/useq_byte_plan.sv
module useq_byte_plan import useq_pkg::*; #(
  parameter int            BYTE_W   = 8,
  parameter int            LEN_W    = 8,
  parameter logic [BYTE_W-1:0] HDR_BYTE = 8'h55,
  parameter logic [BYTE_W-1:0] DEV_BYTE = 8'hA0
) (
  input  ph_e                 phase,
  input  logic [BYTE_W-1:0]   op,
  input  logic [2*BYTE_W-1:0] addr,
  input  logic                addr_en,
  input  logic                rd,
  input  logic [LEN_W-1:0]    len,
  input  logic [LEN_W-1:0]    remain,
  input  logic [BYTE_W-1:0]   wr_byte,
  output logic [BYTE_W-1:0]   byte_val,
  output logic                last,
  output logic                rx_byte,
  output ph_e                 nxt
);
  always_comb begin
    byte_val = '0;
    last     = 1'b0;
    rx_byte  = 1'b0;
    nxt      = phase;
    case (phase)
      PH_HDR: begin
        byte_val = HDR_BYTE;
        nxt      = PH_DEV;
      end
      PH_DEV: begin
        byte_val = DEV_BYTE;
        nxt      = PH_OP;
      end
      PH_OP: begin
        byte_val = op;
        last     = !addr_en && (len == '0);
        nxt      = addr_en ? PH_AH : PH_DAT;
      end
      PH_AH: begin
        byte_val = addr[2*BYTE_W-1:BYTE_W];
        nxt      = PH_AL;
      end
      PH_AL: begin
        byte_val = addr[BYTE_W-1:0];
        last     = (len == '0);
        nxt      = PH_DAT;
      end
      PH_DAT: begin
        byte_val = rd ? '0 : wr_byte;
        last     = (remain == LEN_W'(1));
        rx_byte  = rd;
        nxt      = PH_DAT;
      end
      default: begin
        nxt = PH_HDR;
      end
    endcase
  end
endmodule

// File: rtl/useq_master.sv
module useq_master import useq_pkg::*; #(
  parameter int                STBY_CYC = 60000,
  parameter int                BYTE_W   = 8,
  parameter int                LEN_W    = 8,
  parameter logic [BYTE_W-1:0] HDR_BYTE = 8'h55,
  parameter logic [BYTE_W-1:0] DEV_BYTE = 8'hA0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic [BYTE_W-1:0]   cmd_op,
  input  logic [2*BYTE_W-1:0] cmd_addr,
  input  logic                cmd_addr_en,
  input  logic                cmd_read,
  input  logic [LEN_W-1:0]    cmd_len,
  input  logic                wr_valid,
  input  logic [BYTE_W-1:0]   wr_data,
  output logic                wr_ready,
  output logic                rd_valid,
  output logic [BYTE_W-1:0]   rd_data,
  output logic                done,
  output logic                error,
  output logic                line_stby,
  output logic                bit_go,
  output logic                bit_op,
  output logic                bit_tx,
  input  logic                bit_done,
  input  logic                bit_rx,
  input  logic                bit_miss
);
  localparam int AW  = 2 * BYTE_W;
  localparam int BCW = $clog2(BYTE_W);

  st_e               st;
  ph_e               ph;
  logic [BYTE_W-1:0] op_r;
  logic [AW-1:0]     addr_r;
  logic              aen_r, rd_r, last_r, rxb_r, busy, need_stby, tstart;
  logic [LEN_W-1:0]  len_r, remain;
  logic [BCW-1:0]    bcnt;

  logic              tfin;
  logic [BYTE_W-1:0] plan_byte, sh_q;
  logic              plan_last, plan_rx, sh_msb, sh_load, sh_shift, can_load, ack_ok;
  ph_e               plan_nxt;

  useq_stby_timer #(.CYC(STBY_CYC)) u_timer (
    .clk(clk), .rst(rst), .start(tstart), .active(line_stby), .fin(tfin)
  );

  useq_byte_plan #(
    .BYTE_W(BYTE_W), .LEN_W(LEN_W), .HDR_BYTE(HDR_BYTE), .DEV_BYTE(DEV_BYTE)
  ) u_plan (
    .phase(ph), .op(op_r), .addr(addr_r), .addr_en(aen_r), .rd(rd_r),
    .len(len_r), .remain(remain), .wr_byte(wr_data),
    .byte_val(plan_byte), .last(plan_last), .rx_byte(plan_rx), .nxt(plan_nxt)
  );

  useq_byte_shifter #(.W(BYTE_W)) u_shift (
    .clk(clk), .rst(rst), .load(sh_load), .load_val(plan_byte),
    .shift(sh_shift), .din(bit_rx), .msb(sh_msb), .q(sh_q)
  );

  assign can_load  = !(ph == PH_DAT && !rd_r && !wr_valid);
  assign sh_load   = (st == S_LOAD) && can_load;
  assign sh_shift  = (st == S_BITS) && busy && bit_done;
  assign ack_ok    = bit_rx && !bit_miss;
  assign cmd_ready = (st == S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      ph        <= PH_HDR;
      op_r      <= '0;
      addr_r    <= '0;
      aen_r     <= 1'b0;
      rd_r      <= 1'b0;
      len_r     <= '0;
      remain    <= '0;
      last_r    <= 1'b0;
      rxb_r     <= 1'b0;
      bcnt      <= '0;
      busy      <= 1'b0;
      need_stby <= 1'b1;
      tstart    <= 1'b0;
      wr_ready  <= 1'b0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      done      <= 1'b0;
      error     <= 1'b0;
      bit_go    <= 1'b0;
      bit_op    <= BOP_SEND;
      bit_tx    <= 1'b1;
    end else begin
      tstart   <= 1'b0;
      wr_ready <= 1'b0;
      rd_valid <= 1'b0;
      done     <= 1'b0;
      error    <= 1'b0;
      bit_go   <= 1'b0;
      case (st)
        S_IDLE: begin
          if (cmd_valid) begin
            op_r   <= cmd_op;
            addr_r <= cmd_addr;
            aen_r  <= cmd_addr_en;
            rd_r   <= cmd_read;
            len_r  <= cmd_len;
            remain <= cmd_len;
            ph     <= PH_HDR;
            if (need_stby) begin
              tstart <= 1'b1;
              st     <= S_STBY;
            end else begin
              st <= S_LOAD;
            end
          end
        end
        S_STBY: begin
          if (tfin) begin
            need_stby <= 1'b0;
            st        <= S_LOAD;
          end
        end
        S_LOAD: begin
          if (can_load) begin
            last_r   <= plan_last;
            rxb_r    <= plan_rx;
            bcnt     <= '0;
            wr_ready <= (ph == PH_DAT) && !rd_r;
            st       <= S_BITS;
          end
        end
        S_BITS: begin
          if (!busy) begin
            bit_go <= 1'b1;
            busy   <= 1'b1;
            bit_op <= rxb_r ? BOP_RECV : BOP_SEND;
            bit_tx <= rxb_r ? 1'b1 : sh_msb;
          end else if (bit_done) begin
            busy <= 1'b0;
            bcnt <= bcnt + 1'b1;
            if (bcnt == BCW'(BYTE_W - 1)) st <= S_MAK;
          end
        end
        S_MAK: begin
          if (!busy) begin
            bit_go <= 1'b1;
            busy   <= 1'b1;
            bit_op <= BOP_SEND;
            bit_tx <= !last_r;
          end else if (bit_done) begin
            busy <= 1'b0;
            st   <= S_SAK;
          end
        end
        S_SAK: begin
          if (!busy) begin
            bit_go <= 1'b1;
            busy   <= 1'b1;
            bit_op <= BOP_RECV;
            bit_tx <= 1'b1;
          end else if (bit_done) begin
            busy <= 1'b0;
            if (ph == PH_HDR) begin
              ph <= plan_nxt;
              st <= S_LOAD;
            end else if (!ack_ok) begin
              error     <= 1'b1;
              need_stby <= 1'b1;
              st        <= S_IDLE;
            end else begin
              if (rxb_r) begin
                rd_valid <= 1'b1;
                rd_data  <= sh_q;
              end
              if (ph == PH_DAT) remain <= remain - 1'b1;
              if (last_r) begin
                done <= 1'b1;
                st   <= S_IDLE;
              end else begin
                ph <= plan_nxt;
                st <= S_LOAD;
              end
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/useq_master_chk.sv
module useq_master_chk #(
  parameter int STBY_CYC = 60000
) (
  input logic clk,
  input logic rst,
  input logic line_stby,
  input logic bit_go,
  input logic bit_done,
  input logic bit_rx,
  input logic bit_miss,
  input logic done,
  input logic error,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic rd_valid
);
  localparam int CW = $clog2(STBY_CYC + 2);
  logic [CW-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst)            hi_cnt <= '0;
    else if (line_stby) hi_cnt <= hi_cnt + 1'b1;
    else                hi_cnt <= '0;
  end

  p_stby_len_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(line_stby) |-> (hi_cnt == CW'(STBY_CYC)));

  p_stby_bound_r1: assert property (@(posedge clk) disable iff (rst)
    line_stby |-> (hi_cnt < CW'(STBY_CYC)));

  p_no_go_stby_r1: assert property (@(posedge clk) disable iff (rst)
    line_stby |-> !bit_go);

  p_err_on_nack_r6: assert property (@(posedge clk) disable iff (rst)
    error |-> $past(bit_done && !(bit_rx && !bit_miss)));

  p_done_on_ack_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(bit_done && bit_rx && !bit_miss));

  p_accept_r11: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  p_excl_r12: assert property (@(posedge clk) disable iff (rst)
    !(done && error));

  p_idle_end_r12: assert property (@(posedge clk) disable iff (rst)
    (done || error) |-> cmd_ready);

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_go_pulse: assert property (@(posedge clk) disable iff (rst)
    bit_go |=> !bit_go);

  p_rd_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);
endmodule

bind useq_master useq_master_chk #(.STBY_CYC(STBY_CYC)) u_chk (
  .clk(clk), .rst(rst), .line_stby(line_stby), .bit_go(bit_go),
  .bit_done(bit_done), .bit_rx(bit_rx), .bit_miss(bit_miss),
  .done(done), .error(error), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .rd_valid(rd_valid)
);

// File: tb/tb_useq_master.sv
module tb_useq_master;
  localparam int STBY = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0, cmd_ready;
  logic [7:0] cmd_op = '0;
  logic [15:0] cmd_addr = '0;
  logic       cmd_addr_en = 1'b0, cmd_read = 1'b0;
  logic [7:0] cmd_len = '0;
  logic       wr_valid = 1'b1;
  logic [7:0] wr_data;
  logic       wr_ready, rd_valid, done, error, line_stby;
  logic [7:0] rd_data;
  logic       bit_go, bit_op, bit_tx;
  logic       bit_done = 1'b0, bit_rx = 1'b0, bit_miss = 1'b0;

  always #2.5 clk = ~clk;

  useq_master #(.STBY_CYC(STBY)) dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_addr_en(cmd_addr_en),
    .cmd_read(cmd_read), .cmd_len(cmd_len), .wr_valid(wr_valid),
    .wr_data(wr_data), .wr_ready(wr_ready), .rd_valid(rd_valid),
    .rd_data(rd_data), .done(done), .error(error), .line_stby(line_stby),
    .bit_go(bit_go), .bit_op(bit_op), .bit_tx(bit_tx),
    .bit_done(bit_done), .bit_rx(bit_rx), .bit_miss(bit_miss)
  );

  typedef struct packed {
    logic [7:0]  op;
    logic        aen;
    logic        rd;
    logic [15:0] addr;
    logic [7:0]  len;
    logic [7:0]  seed;
    logic [7:0]  nack;
    logic        hdr_ack;
    logic        hold;
    logic        exp_stby;
    logic        exp_err;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [0:NV-1] = '{
    '{8'h06, 1'b0, 1'b0, 16'h0000, 8'd0, 8'h00, 8'hFF, 1'b0, 1'b0, 1'b1, 1'b0},
    '{8'h02, 1'b1, 1'b0, 16'h1234, 8'd3, 8'h30, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0},
    '{8'h03, 1'b1, 1'b1, 16'hABCD, 8'd4, 8'hC3, 8'hFF, 1'b1, 1'b0, 1'b0, 1'b0},
    '{8'h02, 1'b1, 1'b0, 16'h0040, 8'd2, 8'h10, 8'd3,  1'b0, 1'b0, 1'b0, 1'b1},
    '{8'h05, 1'b0, 1'b1, 16'h0000, 8'd2, 8'h5A, 8'hFF, 1'b0, 1'b1, 1'b1, 1'b0},
    '{8'h01, 1'b0, 1'b0, 16'h0000, 8'd1, 8'h0C, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0},
    '{8'h03, 1'b1, 1'b1, 16'h00FF, 8'd2, 8'h81, 8'd6,  1'b0, 1'b0, 1'b0, 1'b1},
    '{8'h04, 1'b0, 1'b0, 16'h0000, 8'd0, 8'h00, 8'hFF, 1'b0, 1'b0, 1'b1, 1'b0}
  };

  int checks = 0, fails = 0;

  // expected streams
  logic etx [0:1023]; int etn;
  logic rv [0:1023]; logic rm [0:1023]; int rn;
  logic [7:0] erd [0:63]; int ern;
  // observed
  logic atx [0:1023]; int atn = 0;
  int ri = 0;
  logic [7:0] ard [0:63]; int arn = 0;
  int stby_len = 0, stby_cur = 0, go_in_stby = 0;
  logic [7:0] wseed = 8'h00; int widx = 0;

  assign wr_data = wseed + 8'(widx);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] txbyte(input vec_t v, input int j);
    if (j == 0) return 8'h55;
    if (j == 1) return 8'hA0;
    if (j == 2) return v.op;
    if (v.aen && j == 3) return v.addr[15:8];
    if (v.aen && j == 4) return v.addr[7:0];
    return v.seed + 8'(j - (v.aen ? 5 : 3));
  endfunction

  task automatic build(input vec_t v);
    int ntx, nrd; logic [7:0] b; bit stop;
    ntx = 3 + (v.aen ? 2 : 0) + (v.rd ? 0 : int'(v.len));
    nrd = v.rd ? int'(v.len) : 0;
    etn = 0; rn = 0; ern = 0; stop = 0;
    for (int j = 0; j < ntx + nrd && !stop; j++) begin
      if (j < ntx) begin
        b = txbyte(v, j);
        for (int i = 7; i >= 0; i--) begin etx[etn] = b[i]; etn++; end
      end else begin
        b = v.seed + 8'(8'h11 * (j - ntx));
        for (int i = 7; i >= 0; i--) begin rv[rn] = b[i]; rm[rn] = 1'b0; rn++; end
      end
      etx[etn] = (j != ntx + nrd - 1); etn++;
      if (j == 0) begin
        rv[rn] = v.hdr_ack; rm[rn] = !v.hdr_ack; rn++;
      end else if (j == int'(v.nack)) begin
        rv[rn] = 1'b0; rm[rn] = 1'b1; rn++; stop = 1;
      end else begin
        rv[rn] = 1'b1; rm[rn] = 1'b0; rn++;
        if (j >= ntx) begin erd[ern] = b; ern++; end
      end
    end
  endtask

  // transceiver model
  initial begin
    forever begin
      @(negedge clk);
      if (bit_go && !rst) begin
        if (bit_op == 1'b0) begin
          if (atn < 1024) atx[atn] = bit_tx;
          atn++;
          repeat (2) @(negedge clk);
          bit_rx = 1'b0; bit_miss = 1'b0;
        end else begin
          repeat (2) @(negedge clk);
          if (ri < rn) begin bit_rx = rv[ri]; bit_miss = rm[ri]; end
          else begin bit_rx = 1'b0; bit_miss = 1'b1; end
          ri++;
        end
        bit_done = 1'b1;
        @(negedge clk);
        bit_done = 1'b0;
      end
    end
  end

  // monitors
  initial begin
    forever begin
      @(negedge clk);
      if (line_stby) begin stby_cur++; if (bit_go) go_in_stby++; end
      else if (stby_cur != 0) begin stby_len = stby_cur; stby_cur = 0; end
      if (rd_valid) begin if (arn < 64) ard[arn] = rd_data; arn++; end
      if (wr_ready) widx++;
    end
  end

  task automatic run(input vec_t v, input int idx);
    bit gd, ge; int bad;
    build(v);
    atn = 0; ri = 0; arn = 0; stby_len = 0; go_in_stby = 0;
    wseed = v.seed; widx = 0;
    cmd_op = v.op; cmd_addr = v.addr; cmd_addr_en = v.aen;
    cmd_read = v.rd; cmd_len = v.len; cmd_valid = 1'b1;
    @(negedge clk);
    if (!v.hold) cmd_valid = 1'b0;
    else begin
      // R11: changed inputs while busy must not matter
      cmd_op = 8'hFF; cmd_addr = 16'hFFFF; cmd_len = 8'd9; cmd_read = ~v.rd;
    end
    chk(!cmd_ready, "R11 ready low while busy", cmd_ready, 0);
    gd = 0; ge = 0;
    while (!gd && !ge) begin
      @(negedge clk);
      gd = done; ge = error;
      if (gd || ge) begin
        cmd_valid = 1'b0;
        chk(cmd_ready, "R12 idle at end pulse", cmd_ready, 1);
        chk(!(done && error), "R12 exclusive", done, !error);
      end
    end
    repeat (12) @(negedge clk);
    chk(ge == v.exp_err, $sformatf("R6 outcome vec %0d", idx), ge, v.exp_err);
    chk(stby_len == (v.exp_stby ? STBY : 0),
        $sformatf("R1/R7 standby length vec %0d", idx), stby_len, v.exp_stby ? STBY : 0);
    chk(go_in_stby == 0, "R1 no bit during standby", go_in_stby, 0);
    chk(atn == etn, $sformatf("R2/R5 sent bit count vec %0d", idx), atn, etn);
    bad = 0;
    for (int k = 0; k < etn && k < atn; k++) if (atx[k] !== etx[k]) bad++;
    chk(bad == 0, $sformatf("R3/R4/R8/R10 sent bit values vec %0d", idx), bad, 0);
    chk(ri == rn, $sformatf("R6 receive slot count vec %0d", idx), ri, rn);
    chk(arn == ern, $sformatf("R9 read byte count vec %0d", idx), arn, ern);
    for (int k = 0; k < ern && k < arn; k++)
      chk(ard[k] == erd[k], $sformatf("R9 read byte %0d vec %0d", k, idx), ard[k], erd[k]);
    if (!v.rd)
      chk(widx == (v.exp_err ? widx : int'(v.len)), "R8 write bytes taken", widx, v.len);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state
    chk(cmd_ready == 1'b1, "R11 reset ready", cmd_ready, 1);
    chk(!line_stby && !bit_go && !done && !error && !rd_valid && !wr_ready,
        "R12 reset outputs quiet", {line_stby, bit_go, done, error}, 0);
    for (int n = 0; n < NV; n++) run(VEC[n], n);
    // directed: reset in the middle of a read forces a new standby (R1)
    build(VEC[2]);
    atn = 0; ri = 0;
    cmd_op = 8'h03; cmd_addr_en = 1'b1; cmd_read = 1'b1; cmd_len = 8'd2;
    cmd_valid = 1'b1;
    @(negedge clk); cmd_valid = 1'b0;
    repeat (60) @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (6) @(negedge clk);
    chk(cmd_ready && !line_stby, "R1 idle after mid-command reset", cmd_ready, 1);
    run(VEC[5] ^ '0 | vec_t'({8'h01, 1'b0, 1'b0, 16'h0, 8'd1, 8'h0C, 8'hFF, 1'b0, 1'b0, 1'b1, 1'b0}), 99);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule